// File: doc/BRIEF.md
# Read-Fault Injecting SRAM Model

This block is a synthesizable behavioural SRAM that serves as a target for memory test engines. It stores data correctly at all times, but the word it returns on a read can be corrupted by one or more configurable read-fault mechanisms. Each mechanism acts per bit column, or per row, and depends on the contents or recent history of that column. The array itself is never modified by a faulty read.

The memory port performs one operation per cycle: a write, a read, or nothing. Read data is registered and appears one cycle after the read. A separate configuration port loads the fault masks. It is honoured only in cycles with no memory operation. Every active fault condition on a bit forces that bit to the complement of its stored value. Several conditions on the same bit combine as a logical OR, so they never cancel each other.

A three-state machine records the previous cycle's operation:
- LAST_NONE: after reset or an idle cycle.
- LAST_WR: after a write.
- LAST_RD: after a read.

The machine has three transitions, each taken from any state:
- go_idle: taken when `mem_en` is low, and leads to LAST_NONE.
- go_write: taken when `mem_en` and `mem_we` are high, and leads to LAST_WR.
- go_read: taken when `mem_en` is high and `mem_we` is low, and leads to LAST_RD.

Alongside the state, the row and the data of that previous operation are kept. For a read, the data kept is the stored word, not the returned one.

Top module: `rdfault_sram`

## Requirements
- R1: After reset, `mem_rdata` is 0, `mem_rvalid` is 0, every mask is clear and every stored bit is 0.
- R2: With all masks clear, a read returns the stored word on `mem_rdata` one cycle later, with `mem_rvalid` high for exactly that cycle. A write stores `mem_wdata` at `mem_addr`.
- R3: A read never changes stored contents. After faulty reads, clearing the masks and reading returns the original words.
- R4: Leakage. On a column set in the leakage mask, reading a cell returns the wrong bit when every other cell of that column holds the opposite of this cell's value.
- R5: Unrestored after write. On a column set in its mask, a read that directly follows a write to a different row returns the wrong bit when the written bit differs from the cell's stored bit.
- R6: Unrestored after read. On a column set in its mask, a read that directly follows a read of a different row returns the wrong bit when the earlier cell's stored bit differs from this cell's stored bit.
- R7: Slow word line. Every bit read from a row set in the row mask is inverted, whatever the data.
- R8: Sense offset. On a column set in the offset mask, with a bias bit B, a read of a cell holding the complement of B returns B. A read of a cell holding B is correct.
- R9: Columns outside a fault's mask are never affected by that fault.
- R10: An idle cycle between operations, or a read of the same row as the previous operation, never triggers the R5 or R6 faults.
- R11: Configuration writes (`cfg_we`) select a register by `cfg_sel`: 0 is the leakage mask, 1 the after-write mask, 2 the after-read mask, 3 the offset mask, 4 the offset bias bits and 5 the row mask. Column masks take the low bits of `cfg_wdata`, and bit i maps to column or row i. A configuration write in a cycle with `mem_en` high is ignored.
- R12: When several fault conditions hold on one bit in the same read, the bit is still returned inverted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_en | input | 1 | Memory operation this cycle |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | AW | Row address |
| mem_wdata | input | COLS | Write data, one bit per column |
| mem_rdata | output | COLS | Registered read data, possibly faulted |
| mem_rvalid | output | 1 | High the cycle after a read |
| cfg_we | input | 1 | Configuration register write |
| cfg_sel | input | 3 | Configuration register select (see R11) |
| cfg_wdata | input | DW | Configuration data, DW = max(ROWS, COLS) |

## Verification
The bench goes after the following corner cases:
- Leakage boundary: only one cell in a column differs from the others. A design that tested the stored-ones count against the wrong limit would either miss this case or fire when two cells differ.
- Restore faults: back-to-back pairs, pairs separated by an idle cycle, and same-row pairs. A design that did not clear its history on idle, or did not compare rows, would corrupt reads that ought to be clean.
- Overlapping faults on one bit: a design that combined conditions by XOR would return the correct value there.
- Configuration during a memory operation, and re-reading after faults are removed: these expose a design whose masks change mid-operation or whose faulty reads write back into the array.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [1:0] {
        LAST_NONE = 2'd0,
        LAST_WR   = 2'd1,
        LAST_RD   = 2'd2
    } last_op_e;

    localparam logic [2:0] SEL_LEAK  = 3'd0;
    localparam logic [2:0] SEL_URW   = 3'd1;
    localparam logic [2:0] SEL_URR   = 3'd2;
    localparam logic [2:0] SEL_SA    = 3'd3;
    localparam logic [2:0] SEL_BIAS  = 3'd4;
    localparam logic [2:0] SEL_ROW   = 3'd5;
endpackage

// File: rtl/rfs_cfg.sv
module rfs_cfg #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            mem_busy,
    output logic [COLS-1:0] leak_m,
    output logic [COLS-1:0] urw_m,
    output logic [COLS-1:0] urr_m,
    output logic [COLS-1:0] sa_m,
    output logic [COLS-1:0] sa_bias,
    output logic [ROWS-1:0] row_m
);
    import rfs_pkg::*;

    logic take;
    assign take = cfg_we && !mem_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leak_m  <= '0;
            urw_m   <= '0;
            urr_m   <= '0;
            sa_m    <= '0;
            sa_bias <= '0;
            row_m   <= '0;
        end else if (take) begin
            case (cfg_sel)
                SEL_LEAK: leak_m  <= cfg_wdata[COLS-1:0];
                SEL_URW:  urw_m   <= cfg_wdata[COLS-1:0];
                SEL_URR:  urr_m   <= cfg_wdata[COLS-1:0];
                SEL_SA:   sa_m    <= cfg_wdata[COLS-1:0];
                SEL_BIAS: sa_bias <= cfg_wdata[COLS-1:0];
                SEL_ROW:  row_m   <= cfg_wdata[ROWS-1:0];
                default: ;
            endcase
        end
    end

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |=> ($stable(leak_m) && $stable(urw_m) && $stable(urr_m)
                      && $stable(sa_m) && $stable(sa_bias) && $stable(row_m)));
endmodule

// File: rtl/rfs_array.sv
module rfs_array #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int AW   = 3,
    parameter int CW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [COLS-1:0]          wdata,
    output logic [COLS-1:0]          rd_word,
    output logic [COLS-1:0][CW-1:0]  ones
);
    logic [ROWS-1:0][COLS-1:0] mem_q;

    assign rd_word = mem_q[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else if (en && we) mem_q[addr] <= wdata;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ones[c] <= '0;
            else if (en && we)
                ones[c] <= ones[c] + CW'(wdata[c]) - CW'(mem_q[addr][c]);
        end

        p_ones_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ones[c] <= CW'(ROWS));
    end

    p_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> $stable(mem_q));
endmodule

// File: rtl/rfs_fault.sv
module rfs_fault #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    parameter int AW   = 3,
    parameter int CW   = 4
) (
    input  logic [COLS-1:0]          rd_word,
    input  logic [COLS-1:0][CW-1:0]  ones,
    input  logic [AW-1:0]            addr,
    input  logic                     row_hit,
    input  rfs_pkg::last_op_e        last_op,
    input  logic [AW-1:0]            last_row,
    input  logic [COLS-1:0]          last_data,
    input  logic [COLS-1:0]          leak_m,
    input  logic [COLS-1:0]          urw_m,
    input  logic [COLS-1:0]          urr_m,
    input  logic [COLS-1:0]          sa_m,
    input  logic [COLS-1:0]          sa_bias,
    output logic [COLS-1:0]          flip
);
    import rfs_pkg::*;

    logic other_row;
    assign other_row = (last_row != addr);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic v, leak_hit, urw_hit, urr_hit, sa_hit;
        assign v        = rd_word[c];
        assign leak_hit = leak_m[c] && (v ? (ones[c] == CW'(1))
                                          : (ones[c] == CW'(ROWS - 1)));
        assign urw_hit  = urw_m[c] && (last_op == LAST_WR) && other_row
                          && (last_data[c] != v);
        assign urr_hit  = urr_m[c] && (last_op == LAST_RD) && other_row
                          && (last_data[c] != v);
        assign sa_hit   = sa_m[c] && (sa_bias[c] != v);
        assign flip[c]  = leak_hit | urw_hit | urr_hit | sa_hit | row_hit;
    end
endmodule

// File: rtl/rdfault_sram.sv
module rdfault_sram #(
    parameter int ROWS = 8,
    parameter int COLS = 4,
    localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DW  = (ROWS > COLS) ? ROWS : COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_en,
    input  logic            mem_we,
    input  logic [AW-1:0]   mem_addr,
    input  logic [COLS-1:0] mem_wdata,
    output logic [COLS-1:0] mem_rdata,
    output logic            mem_rvalid,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata
);
    import rfs_pkg::*;

    localparam int CW = $clog2(ROWS + 1);

    logic [COLS-1:0]         leak_m, urw_m, urr_m, sa_m, sa_bias, flip, rd_word;
    logic [ROWS-1:0]         row_m;
    logic [COLS-1:0][CW-1:0] ones;
    last_op_e                last_q, last_d;
    logic [AW-1:0]           last_row;
    logic [COLS-1:0]         last_data;
    logic                    is_read;

    assign is_read = mem_en && !mem_we;

    rfs_cfg #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_busy(mem_en),
        .leak_m(leak_m), .urw_m(urw_m), .urr_m(urr_m),
        .sa_m(sa_m), .sa_bias(sa_bias), .row_m(row_m));

    rfs_array #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .CW(CW)) u_arr (
        .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rd_word(rd_word), .ones(ones));

    rfs_fault #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .CW(CW)) u_flt (
        .rd_word(rd_word), .ones(ones), .addr(mem_addr),
        .row_hit(row_m[mem_addr]), .last_op(last_q), .last_row(last_row),
        .last_data(last_data), .leak_m(leak_m), .urw_m(urw_m), .urr_m(urr_m),
        .sa_m(sa_m), .sa_bias(sa_bias), .flip(flip));

    // next-state: go_idle / go_write / go_read, same from every state
    always_comb begin
        last_d = last_q;
        unique case (last_q)
            LAST_NONE, LAST_WR, LAST_RD: begin
                if (!mem_en)    last_d = LAST_NONE;
                else if (mem_we) last_d = LAST_WR;
                else             last_d = LAST_RD;
            end
            default: last_d = LAST_NONE;
        endcase
    end

    // state register with the record of the previous operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q    <= LAST_NONE;
            last_row  <= '0;
            last_data <= '0;
        end else begin
            last_q <= last_d;
            if (mem_en) begin
                last_row  <= mem_addr;
                last_data <= mem_we ? mem_wdata : rd_word;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rdata  <= '0;
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= is_read;
            if (is_read) mem_rdata <= rd_word ^ flip;
        end
    end

    p_rvalid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> mem_rvalid);
    p_rvalid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> !mem_rvalid);
    p_idle_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |=> (last_q == LAST_NONE));
    p_clean_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && ~|{leak_m, urw_m, urr_m, sa_m, row_m})
        |=> (mem_rdata == $past(rd_word)));
endmodule

// File: tb/sim_rdfault_sram.sv
module sim_rdfault_sram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_en = 1'b0, mem_we = 1'b0;
    logic [2:0] mem_addr = '0;
    logic [3:0] mem_wdata = '0;
    logic [3:0] mem_rdata;
    logic       mem_rvalid;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    logic [3:0] m_mem [8];
    logic [3:0] m_leak = 0, m_urw = 0, m_urr = 0, m_sa = 0, m_bias = 0;
    logic [7:0] m_row = 0;
    int         m_last = 0;  // 0 none, 1 write, 2 read
    int         m_lrow = 0;
    logic [3:0] m_ldata = 0;

    always #4 clk = ~clk;

    rdfault_sram #(.ROWS(8), .COLS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata));

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] expect_rd(int r);
        logic [3:0] v = m_mem[r];
        logic [3:0] e;
        for (int c = 0; c < 4; c++) begin
            bit f = 0;
            bit all_opp = 1;
            for (int k = 0; k < 8; k++)
                if (k != r && m_mem[k][c] == v[c]) all_opp = 0;
            if (m_leak[c] && all_opp) f = 1;
            if (m_urw[c] && m_last == 1 && m_lrow != r && m_ldata[c] != v[c]) f = 1;
            if (m_urr[c] && m_last == 2 && m_lrow != r && m_ldata[c] != v[c]) f = 1;
            if (m_row[r]) f = 1;
            if (m_sa[c] && m_bias[c] != v[c]) f = 1;
            e[c] = v[c] ^ f;
        end
        return e;
    endfunction

    task automatic idle();
        mem_en = 0; cfg_we = 0;
        m_last = 0;
        @(negedge clk);
    endtask

    task automatic wr(int r, logic [3:0] d);
        mem_en = 1; mem_we = 1; mem_addr = 3'(r); mem_wdata = d; cfg_we = 0;
        m_mem[r] = d; m_last = 1; m_lrow = r; m_ldata = d;
        @(negedge clk);
    endtask

    task automatic rd(int r, string tag, bit with_cfg = 0,
                      logic [2:0] sel = 0, logic [7:0] cd = 0);
        logic [3:0] e;
        mem_en = 1; mem_we = 0; mem_addr = 3'(r);
        cfg_we = with_cfg; cfg_sel = sel; cfg_wdata = cd;
        e = expect_rd(r);
        m_last = 2; m_lrow = r; m_ldata = m_mem[r];
        @(negedge clk);
        cfg_we = 0;
        chk(tag, {4'h0, mem_rdata}, {4'h0, e});
        chk({tag, " rvalid"}, {7'h0, mem_rvalid}, 8'h1);
    endtask

    task automatic cfg(logic [2:0] sel, logic [7:0] d);
        mem_en = 0; cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            3'd0: m_leak = d[3:0];
            3'd1: m_urw  = d[3:0];
            3'd2: m_urr  = d[3:0];
            3'd3: m_sa   = d[3:0];
            3'd4: m_bias = d[3:0];
            3'd5: m_row  = d;
            default: ;
        endcase
        m_last = 0;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic clear_cfg();
        for (int s = 0; s < 6; s++) cfg(3'(s), 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 8; i++) m_mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", {4'h0, mem_rdata}, 8'h00);
        chk("R1 rvalid", {7'h0, mem_rvalid}, 8'h00);
        rd(3, "R1 array zero");
        idle();
        chk("R1 rvalid drops", {7'h0, mem_rvalid}, 8'h00);

        // R2: clean write then read, idles between
        for (int r = 0; r < 8; r++) wr(r, 4'(r * 5 + 3));
        idle();
        for (int r = 0; r < 8; r++) begin rd(r, "R2 clean read"); idle(); end

        // R4: leakage boundary, mask on columns 0 and 2 (R9 for 1,3)
        for (int r = 0; r < 8; r++) wr(r, 4'h0);
        wr(0, 4'hF); idle();
        cfg(3'd0, 8'h05);
        rd(0, "R4 lone one"); idle();
        rd(1, "R4 zero cell clean"); idle();
        for (int r = 0; r < 8; r++) wr(r, 4'hF);
        wr(3, 4'h0); idle();
        rd(3, "R4 lone zero"); idle();
        rd(4, "R4 one cell clean"); idle();
        wr(5, 4'h0); idle();
        rd(3, "R4 two differ clean"); idle();

        // R3: stored contents survive faulty reads
        clear_cfg();
        rd(0, "R3 row0 intact"); idle();
        rd(3, "R3 row3 intact"); idle();

        // R5: unrestored after write, mask 0110
        wr(2, 4'hF); idle();
        cfg(3'd1, 8'h06);
        wr(1, 4'h0); rd(2, "R5 write then read"); idle();
        wr(1, 4'hF); rd(2, "R5 same data clean"); idle();
        wr(2, 4'h0); rd(2, "R10 same row clean"); idle();
        wr(1, 4'hF); idle(); rd(2, "R10 idle breaks"); idle();

        // R6: unrestored after read, all columns
        clear_cfg();
        wr(4, 4'h0); wr(6, 4'hF); wr(7, 4'h5); idle();
        cfg(3'd2, 8'h0F);
        rd(4, "R6 first"); rd(6, "R6 after read"); rd(7, "R6 chain");
        rd(7, "R10 same row read"); idle();
        rd(6, "R10 idle breaks read"); idle();

        // R7: slow row 5
        clear_cfg();
        cfg(3'd5, 8'h20);
        rd(5, "R7 slow row"); idle();
        rd(4, "R7 other row"); idle();

        // R8: sense offset, columns 0,1 biased to 1
        clear_cfg();
        cfg(3'd3, 8'h03); cfg(3'd4, 8'h03);
        rd(4, "R8 zeros biased"); idle();
        rd(6, "R8 ones clean"); idle();

        // R12: row fault and offset fault on the same bit
        cfg(3'd5, 8'h10);
        rd(4, "R12 overlap"); idle();

        // R11: configuration during memory op ignored
        clear_cfg();
        rd(5, "R11 cfg during read", 1, 3'd5, 8'h20); idle();
        rd(5, "R11 row mask unchanged"); idle();
        mem_en = 1; mem_we = 1; mem_addr = 3'd0; mem_wdata = 4'h9;
        cfg_we = 1; cfg_sel = 3'd0; cfg_wdata = 8'h0F;
        m_mem[0] = 4'h9; m_last = 1; m_lrow = 0; m_ldata = 4'h9;
        @(negedge clk); cfg_we = 0;
        idle();
        rd(0, "R11 cfg during write"); idle();

        // R12: sweep with mixed masks
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i % 150 == 0) begin
                cfg(3'd0, {4'h0, lf[3:0]});
                cfg(3'd1, {4'h0, lf[7:4]});
                cfg(3'd2, {4'h0, lf[11:8]});
                cfg(3'd3, {4'h0, lf[15:12]});
                cfg(3'd4, {4'h0, lf[5:2]});
                cfg(3'd5, {lf[0], 7'h0});
            end else begin
                case (lf[1:0])
                    2'd0: idle();
                    2'd1: wr(int'(lf[4:2]), lf[8:5]);
                    default: rd(int'(lf[4:2]), "R12 sweep");
                endcase
            end
        end
        idle();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule